// File: doc/BRIEF.md
# Receive Path Desensitizing Noise Injector

This block lowers the effective sensitivity of four receive input lanes on purpose. It flips chosen bits of each 16-bit input sample with pseudo-random bits from one shared linear feedback shift register. Each lane has its own 16-bit mask that picks the bit positions to disturb. A bit position whose mask bit is clear passes through unchanged.

Noise is applied only when two conditions hold together: the generator is out of its hold (sync) state, and the test-mode select is set to random. In all other cases every lane passes its sample straight through. The result is always registered, so the lane outputs follow the inputs by exactly one clock, whatever the mask and mode settings are.

Top module: `rx_desense_noise`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four lane outputs become zero after that edge, and the generator state is loaded with the seed 23'h2A5F3C.
- R2: When all four masks are zero, each lane output equals that lane's input from the previous clock edge.
- R3: When noise is enabled, each output bit equals the input bit XOR the lane's noise bit wherever the lane mask bit is 1.
- R4: While `pn_hold` is high, noise is disabled and the generator is held at the seed. In the first cycle after release, the noise used is the seed itself.
- R5: Noise is enabled only when `test_mode` equals 2'b01 (random). The values 2'b00, 2'b10 and 2'b11 give pass-through.
- R6: When not held, the generator is a 23-bit Fibonacci register with feedback bit s[22]^s[17] (polynomial x^23+x^18+1), shifted in at bit 0. It advances 16 shift steps per clock.
- R7: Lane k (A=0, B=1, C=2, D=3) takes noise bits state[2k+15:2k] of the generator state. Output bit i of the lane uses state bit 2k+i.
- R8: Output bits whose mask bit is 0 always equal the corresponding input bits from the previous edge.
- R9: Every lane output has exactly one clock of latency from its input, whether masks are zero or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| pn_hold | input | 1 | Holds the generator at its seed and disables noise |
| test_mode | input | 2 | Test mode select; 2'b01 means random |
| samp_a | input | 16 | Lane A input sample |
| samp_b | input | 16 | Lane B input sample |
| samp_c | input | 16 | Lane C input sample |
| samp_d | input | 16 | Lane D input sample |
| mask_a | input | 16 | Lane A noise mask |
| mask_b | input | 16 | Lane B noise mask |
| mask_c | input | 16 | Lane C noise mask |
| mask_d | input | 16 | Lane D noise mask |
| dout_a | output | 16 | Lane A registered output |
| dout_b | output | 16 | Lane B registered output |
| dout_c | output | 16 | Lane C registered output |
| dout_d | output | 16 | Lane D registered output |

## Verification
Full masks on all-zero inputs expose the raw noise of every lane. This separates the per-lane slice offsets from one another and checks the seed and the 16-step advance against a generator model kept in the bench. Varied input samples with zero masks prove plain pass-through and the one-cycle latency. Partial masks on busy samples show that only masked positions move. Full masks combined with hold, and with each non-random test mode, show that either condition alone is enough to suppress noise.

// File: rtl/desense_pkg.sv
package desense_pkg;
  localparam int LANES     = 4;
  localparam int SAMPLE_W  = 16;
  localparam int MODE_W    = 2;

  typedef enum logic [MODE_W-1:0] {
    TM_NORMAL = 2'd0,
    TM_RANDOM = 2'd1,
    TM_RSVD2  = 2'd2,
    TM_RSVD3  = 2'd3
  } test_mode_e;
endpackage

// File: rtl/pn_source.sv
module pn_source #(
  parameter int STATE_W = 23,
  parameter int TAP_HI  = 23,
  parameter int TAP_LO  = 18,
  parameter int STEPS   = 16,
  parameter logic [STATE_W-1:0] SEED = 23'h2A5F3C
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold,
  output logic [STATE_W-1:0] state
);
  localparam int HI_IDX = TAP_HI - 1;
  localparam int LO_IDX = TAP_LO - 1;

  logic [STATE_W-1:0] state_q;

  // Advance the Fibonacci register by STEPS single-bit shifts.
  function automatic logic [STATE_W-1:0] advance(input logic [STATE_W-1:0] s_in);
    logic [STATE_W-1:0] s;
    logic fb;
    s = s_in;
    for (int i = 0; i < STEPS; i++) begin
      fb = s[HI_IDX] ^ s[LO_IDX];
      s  = {s[STATE_W-2:0], fb};
    end
    return s;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || hold) state_q <= SEED;
    else             state_q <= advance(state_q);
  end

  assign state = state_q;

  assert_hold_seed_R4: assert property (@(posedge clk) disable iff (rst)
    hold |=> (state_q == SEED));

  assert_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  assert_moves_R6: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (state_q != $past(state_q)));
endmodule

// File: rtl/lane_mixer.sv
module lane_mixer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         noise_en,
  input  logic [W-1:0] din,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] noise,
  output logic [W-1:0] dout
);
  logic [W-1:0] flip;
  logic [W-1:0] dout_q;

  always_comb flip = noise_en ? (mask & noise) : '0;

  always_ff @(posedge clk) begin
    if (rst) dout_q <= '0;
    else     dout_q <= din ^ flip;
  end

  assign dout = dout_q;

  assert_pass_R5: assert property (@(posedge clk) disable iff (rst)
    !noise_en |=> (dout_q == $past(din)));

  assert_zero_mask_R2: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> (dout_q == $past(din)));

  assert_unmasked_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((dout_q ^ $past(din)) & ~$past(mask)) == '0));
endmodule

// File: rtl/rx_desense_noise.sv
module rx_desense_noise
  import desense_pkg::*;
#(
  parameter int W          = SAMPLE_W,
  parameter int STATE_W    = 23,
  parameter int SLICE_STEP = 2,
  parameter logic [STATE_W-1:0] SEED = 23'h2A5F3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pn_hold,
  input  logic [MODE_W-1:0] test_mode,
  input  logic [W-1:0]      samp_a,
  input  logic [W-1:0]      samp_b,
  input  logic [W-1:0]      samp_c,
  input  logic [W-1:0]      samp_d,
  input  logic [W-1:0]      mask_a,
  input  logic [W-1:0]      mask_b,
  input  logic [W-1:0]      mask_c,
  input  logic [W-1:0]      mask_d,
  output logic [W-1:0]      dout_a,
  output logic [W-1:0]      dout_b,
  output logic [W-1:0]      dout_c,
  output logic [W-1:0]      dout_d
);
  localparam int MAX_OFS = (LANES - 1) * SLICE_STEP;

  logic [STATE_W-1:0] pn_state;
  logic               noise_en;
  logic [W-1:0]       lane_in   [LANES];
  logic [W-1:0]       lane_mask [LANES];
  logic [W-1:0]       lane_out  [LANES];

  initial begin
    if (MAX_OFS + W > STATE_W)
      $error("slice offsets exceed generator width");
  end

  pn_source #(
    .STATE_W(STATE_W),
    .TAP_HI (23),
    .TAP_LO (18),
    .STEPS  (W),
    .SEED   (SEED)
  ) u_pn (
    .clk  (clk),
    .rst  (rst),
    .hold (pn_hold),
    .state(pn_state)
  );

  always_comb noise_en = !pn_hold && (test_mode == TM_RANDOM);

  assign lane_in[0] = samp_a;  assign lane_mask[0] = mask_a;
  assign lane_in[1] = samp_b;  assign lane_mask[1] = mask_b;
  assign lane_in[2] = samp_c;  assign lane_mask[2] = mask_c;
  assign lane_in[3] = samp_d;  assign lane_mask[3] = mask_d;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lane_mixer #(.W(W)) u_mix (
      .clk     (clk),
      .rst     (rst),
      .noise_en(noise_en),
      .din     (lane_in[k]),
      .mask    (lane_mask[k]),
      .noise   (pn_state[k*SLICE_STEP +: W]),
      .dout    (lane_out[k])
    );
  end

  assign dout_a = lane_out[0];
  assign dout_b = lane_out[1];
  assign dout_c = lane_out[2];
  assign dout_d = lane_out[3];

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (dout_a == '0 && dout_b == '0 && dout_c == '0 && dout_d == '0));

  assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    pn_hold |=> (dout_a == $past(samp_a) && dout_d == $past(samp_d)));
endmodule

// File: tb/sim_rx_desense_noise.sv
`timescale 1ns/1ps
module sim_rx_desense_noise;
  localparam logic [22:0] SEED_V = 23'h2A5F3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pn_hold = 1'b1;
  logic [1:0]  test_mode = 2'd0;
  logic [15:0] samp [4];
  logic [15:0] mask [4];
  logic [15:0] got  [4];
  logic [15:0] exp_q[4];
  logic [22:0] mstate;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  rx_desense_noise u0 (
    .clk(clk), .rst(rst), .pn_hold(pn_hold), .test_mode(test_mode),
    .samp_a(samp[0]), .samp_b(samp[1]), .samp_c(samp[2]), .samp_d(samp[3]),
    .mask_a(mask[0]), .mask_b(mask[1]), .mask_c(mask[2]), .mask_d(mask[3]),
    .dout_a(got[0]), .dout_b(got[1]), .dout_c(got[2]), .dout_d(got[3])
  );

  function automatic logic [22:0] step16(input logic [22:0] s_in);
    logic [22:0] s;
    s = s_in;
    for (int i = 0; i < 16; i++) s = {s[21:0], s[22] ^ s[17]};
    return s;
  endfunction

  // Bench reference built from R1..R9.
  always @(posedge clk) begin
    logic en;
    en = !pn_hold && (test_mode == 2'b01);
    for (int k = 0; k < 4; k++)
      exp_q[k] <= rst ? 16'h0 : (samp[k] ^ (en ? (mask[k] & mstate[2*k +: 16]) : 16'h0));
    mstate <= (rst || pn_hold) ? SEED_V : step16(mstate);
  end

  task automatic chk(input string tag, input int k, input logic [15:0] e);
    checks++;
    if (got[k] !== e) begin
      errors++;
      $display("FAIL %s lane %0d: got %h expected %h", tag, k, got[k], e);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cmp_all(input string tag);
    for (int k = 0; k < 4; k++) chk(tag, k, exp_q[k]);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    for (int k = 0; k < 4; k++) begin samp[k] = 16'hFFFF; mask[k] = 16'hFFFF; end
    cyc();
    for (int k = 0; k < 4; k++) chk("R1 reset", k, 16'h0000);
    rst = 1'b0;
  endtask

  task automatic t_passthru();
    pn_hold = 1'b0; test_mode = 2'b01;
    for (int k = 0; k < 4; k++) mask[k] = 16'h0;
    for (int n = 0; n < 6; n++) begin
      for (int k = 0; k < 4; k++) samp[k] = 16'h1234 * (n + 1) + 16'h0F0F * k;
      cyc();
      for (int k = 0; k < 4; k++) chk("R2 R9 zero mask", k, 16'h1234 * (n + 1) + 16'h0F0F * k);
    end
  endtask

  task automatic t_seed_slices();
    logic [22:0] nxt;
    pn_hold = 1'b1; test_mode = 2'b01;
    for (int k = 0; k < 4; k++) begin samp[k] = 16'h0; mask[k] = 16'hFFFF; end
    cyc(); cyc();
    for (int k = 0; k < 4; k++) chk("R4 held", k, 16'h0000);
    pn_hold = 1'b0;
    cyc();
    for (int k = 0; k < 4; k++) chk("R4 R7 seed slice", k, SEED_V[2*k +: 16]);
    nxt = step16(SEED_V);
    cyc();
    for (int k = 0; k < 4; k++) chk("R6 R7 first advance", k, nxt[2*k +: 16]);
    for (int n = 0; n < 20; n++) begin cyc(); cmp_all("R6 stream"); end
  endtask

  task automatic t_partial();
    pn_hold = 1'b0; test_mode = 2'b01;
    mask[0] = 16'h00FF; mask[1] = 16'hF000; mask[2] = 16'h5555; mask[3] = 16'h8001;
    for (int n = 0; n < 12; n++) begin
      for (int k = 0; k < 4; k++) samp[k] = 16'hA5C3 ^ (16'h1111 * n) ^ (16'h0101 << k);
      cyc();
      for (int k = 0; k < 4; k++) begin
        checks++;
        if (((got[k] ^ samp[k]) & ~mask[k]) !== 16'h0) begin
          errors++;
          $display("FAIL R8 lane %0d: got %h expected unmasked bits of %h", k, got[k], samp[k]);
        end
      end
      cmp_all("R3 partial mask");
    end
  endtask

  task automatic t_hold_full();
    pn_hold = 1'b1; test_mode = 2'b01;
    for (int k = 0; k < 4; k++) begin samp[k] = 16'hBEEF + k; mask[k] = 16'hFFFF; end
    cyc();
    for (int k = 0; k < 4; k++) chk("R4 hold suppresses", k, 16'hBEEF + k);
    pn_hold = 1'b0;
  endtask

  task automatic t_modes();
    logic [1:0] m;
    for (int v = 0; v < 4; v++) begin
      m = v[1:0];
      if (m == 2'b01) continue;
      test_mode = m; pn_hold = 1'b0;
      for (int k = 0; k < 4; k++) begin samp[k] = 16'h3C3C ^ (16'h0011 * v) ^ k; mask[k] = 16'hFFFF; end
      cyc();
      for (int k = 0; k < 4; k++) chk("R5 non-random mode", k, 16'h3C3C ^ (16'h0011 * v) ^ k);
    end
    test_mode = 2'b01;
    cyc();
    cmp_all("R5 random again");
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin samp[k] = 16'h0; mask[k] = 16'h0; end
    @(negedge clk);
    t_reset();
    t_passthru();
    t_seed_slices();
    t_partial();
    t_hold_full();
    t_modes();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule